// File: doc/BRIEF.md
# Dual Tone-List Store and Matcher

This block keeps two separate lists of tone definitions, each up to 32 entries deep, and searches the active list for the first entry that agrees with a measured tone code. An entry is a 16-bit word. Its two top bits say which tone group or groups the entry belongs to. The remaining 14 bits hold the frequency code, which is a 7-bit N field above a 7-bit R field. The two fields are compared together as a single 14-bit number.

Entries are loaded through a valid/ready write port into whichever list `list_sel` names. Loading starts at location 0 and moves upward. Once a list holds 32 entries, each new write drops the oldest one, so the list always keeps the 32 most recent writes, oldest at location 0. The write port has back-pressure: `wr_ready` is low while a scan runs and during a cycle that carries `clear`. A write takes place only on a cycle where both `wr_valid` and `wr_ready` are high, and the source may hold `wr_valid` high across stalled cycles.

A one-cycle `scan_start` captures the list select, group mode, measured code and tolerance. The block then checks one location per clock, starting at location 0. It raises `done` for one cycle with the result. The result outputs stay as they are until the next `done`. The result port has no back-pressure.

Top module: `tone_list_matcher`

## Requirements
- R1: Entry bit 15 marks membership of the first group and bit 14 marks membership of the second group. Bits 13:0 are the frequency code. Group mode `2'b10` searches the first group and `2'b01` searches the second group.
- R2: A write happens on a clock edge where `wr_valid` and `wr_ready` are both high. While the list is not full, the entry goes to the next free location, counting up from location 0.
- R3: When a write arrives at a list that already holds 32 entries, every entry moves down one location and the new entry is stored at location 31. Location 0 always holds the oldest retained write.
- R4: `full` is high exactly when the list named by `list_sel` holds 32 entries. After 31 writes it is still low.
- R5: When `clear` is accepted (no scan running), the selected list is set to all zeros, its fill count returns to zero and its `full` goes low. The other list is not changed.
- R6: Reset clears both fill counts and both `full` flags. It keeps the contents of both lists, and writes made after reset start again at location 0.
- R7: An entry matches when its code is nonzero and the absolute difference between its code and the measured code is no more than `tol`.
- R8: A hit reports the lowest matching location in the enabled group. It gives the stored 16-bit entry on `hit_entry` and its location on `hit_loc`.
- R9: Only entries whose flag agrees with the group mode can hit. Modes `2'b00` and `2'b11` never hit and report `unlisted` = 0.
- R10: With an enabled mode and no hit, `unlisted` is 1 only if no entry of the list matches by code. A code match that fails only on group gives `hit` = 0 and `unlisted` = 0. `hit` and `unlisted` are never both 1.
- R11: `done` is a one-cycle pulse. For a hit at location i it is high i+1 cycles after the edge that samples `scan_start`. When there is no hit it is high 32 cycles after that edge. `hit`, `unlisted`, `hit_entry` and `hit_loc` change only with `done`.
- R12: While a scan runs, `wr_ready` is low and `scan_start` is ignored. The scan uses the list, mode, code and tolerance that were captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the fill state but keeps list contents |
| list_sel | input | 1 | Selects the list for writes, clear, `full` and scan start |
| clear | input | 1 | Zeros the selected list |
| wr_valid | input | 1 | Write entry is offered |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_entry | input | 16 | Entry to store |
| grp_mode | input | 2 | Group to search: 10 first, 01 second, others off |
| meas_code | input | 14 | Measured tone code |
| tol | input | 14 | Allowed absolute code difference |
| scan_start | input | 1 | Begins a scan |
| done | output | 1 | Scan result pulse |
| hit | output | 1 | A listed tone in the enabled group matched |
| unlisted | output | 1 | No stored entry matched the code |
| hit_entry | output | 16 | Stored entry that hit |
| hit_loc | output | 5 | Location of that entry |
| full | output | 1 | Selected list holds 32 entries |

## Verification
For every scan the bench computes the due cycle from R11: i+1 cycles after the start edge for a hit at location i, and 32 cycles when there is no hit. The bench counts falling edges from the start edge until `done` appears and compares that count with the due value, so a result that comes early or late fails even when its contents are correct. Write effects and `full` are sampled on the falling edge one cycle after the accepting edge, because both come from a single register stage. A write offered during a scan is dropped before the scan ends, and later scans then show that the list was not changed.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic [1:0] {
    GM_OFF    = 2'b00,
    GM_SECOND = 2'b01,
    GM_FIRST  = 2'b10,
    GM_BAD    = 2'b11
  } grp_mode_e;

  // Group gate: does the entry's flag pair allow a decode in this mode
  function automatic logic group_ok(input logic [1:0] mode, input logic first_f,
                                    input logic second_f);
    case (grp_mode_e'(mode))
      GM_FIRST:  return first_f;
      GM_SECOND: return second_f;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic mode_on(input logic [1:0] mode);
    return (mode == GM_FIRST) || (mode == GM_SECOND);
  endfunction
endpackage

// File: rtl/tlm_list_store.sv
module tlm_list_store #(
  parameter int DEPTH   = 32,
  parameter int ENTRY_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_idx,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               full
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ADDR_W:0]    cnt;

  assign full    = (cnt == (ADDR_W+1)'(DEPTH));
  assign rd_data = mem[rd_idx];

  // Fill count: cleared by reset or clear, saturates at DEPTH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (wr_en && !full)   cnt <= cnt + (ADDR_W+1)'(1);
  end

  // Storage keeps its contents through reset
  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      if (full) begin
        for (int i = 0; i < DEPTH-1; i++) mem[i] <= mem[i+1];
        mem[DEPTH-1] <= wr_data;
      end else begin
        mem[cnt[ADDR_W-1:0]] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tlm_scanner.sv
module tlm_scanner
  import tlm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int CODE_W  = 14,
  localparam int ENTRY_W = CODE_W + 2,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               list_sel,
  input  logic [1:0]         mode,
  input  logic [CODE_W-1:0]  meas,
  input  logic [CODE_W-1:0]  tol,
  input  logic [ENTRY_W-1:0] rd_entry,
  output logic [ADDR_W-1:0]  rd_idx,
  output logic               scan_list,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic               unlisted,
  output logic [ENTRY_W-1:0] hit_entry,
  output logic [ADDR_W-1:0]  hit_loc
);
  logic [ADDR_W-1:0] idx;
  logic [1:0]        mode_q;
  logic [CODE_W-1:0] meas_q, tol_q;
  logic              seen_q;

  logic [CODE_W-1:0] code, diff;
  logic              near, take, last;

  assign code = rd_entry[CODE_W-1:0];
  assign diff = (code >= meas_q) ? (code - meas_q) : (meas_q - code);
  assign near = (code != '0) && (diff <= tol_q);
  assign take = near && group_ok(mode_q, rd_entry[ENTRY_W-1], rd_entry[ENTRY_W-2]);
  assign last = (idx == ADDR_W'(DEPTH-1));
  assign rd_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      scan_list <= 1'b0;
      mode_q    <= '0;
      meas_q    <= '0;
      tol_q     <= '0;
      seen_q    <= 1'b0;
      done      <= 1'b0;
      hit       <= 1'b0;
      unlisted  <= 1'b0;
      hit_entry <= '0;
      hit_loc   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          idx       <= '0;
          scan_list <= list_sel;
          mode_q    <= mode;
          meas_q    <= meas;
          tol_q     <= tol;
          seen_q    <= 1'b0;
        end
      end else if (take) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        hit       <= 1'b1;
        unlisted  <= 1'b0;
        hit_entry <= rd_entry;
        hit_loc   <= idx;
      end else if (last) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        hit       <= 1'b0;
        unlisted  <= mode_on(mode_q) && !(seen_q || near);
        hit_entry <= '0;
        hit_loc   <= '0;
      end else begin
        idx    <= idx + ADDR_W'(1);
        seen_q <= seen_q || near;
      end
    end
  end
endmodule

// File: rtl/tone_list_matcher.sv
module tone_list_matcher #(
  parameter int DEPTH   = 32,
  parameter int CODE_W  = 14,
  localparam int ENTRY_W = CODE_W + 2,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               list_sel,
  input  logic               clear,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [1:0]         grp_mode,
  input  logic [CODE_W-1:0]  meas_code,
  input  logic [CODE_W-1:0]  tol,
  input  logic               scan_start,
  output logic               done,
  output logic               hit,
  output logic               unlisted,
  output logic [ENTRY_W-1:0] hit_entry,
  output logic [ADDR_W-1:0]  hit_loc,
  output logic               full
);
  localparam int LISTS = 2;

  logic               scan_busy, scan_list;
  logic [ADDR_W-1:0]  rd_idx;
  logic [ENTRY_W-1:0] rd_data [LISTS];
  logic [LISTS-1:0]   full_l;
  logic               wr_take, clr_take;

  assign wr_ready = !scan_busy && !clear;
  assign wr_take  = wr_valid && wr_ready;
  assign clr_take = clear && !scan_busy;
  assign full     = full_l[list_sel];

  for (genvar l = 0; l < LISTS; l++) begin : g_list
    tlm_list_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_take && (list_sel == 1'(l))),
      .wr_en   (wr_take && (list_sel == 1'(l))),
      .wr_data (wr_entry),
      .rd_idx  (rd_idx),
      .rd_data (rd_data[l]),
      .full    (full_l[l])
    );
  end

  tlm_scanner #(.DEPTH(DEPTH), .CODE_W(CODE_W)) scan_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (scan_start),
    .list_sel  (list_sel),
    .mode      (grp_mode),
    .meas      (meas_code),
    .tol       (tol),
    .rd_entry  (rd_data[scan_list]),
    .rd_idx    (rd_idx),
    .scan_list (scan_list),
    .busy      (scan_busy),
    .done      (done),
    .hit       (hit),
    .unlisted  (unlisted),
    .hit_entry (hit_entry),
    .hit_loc   (hit_loc)
  );
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
  parameter int ENTRY_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               list_sel,
  input logic               clear,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               scan_busy,
  input logic               full,
  input logic               done,
  input logic               hit,
  input logic               unlisted,
  input logic [ENTRY_W-1:0] hit_entry
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_entry) |-> done);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(hit && unlisted));

  p_hit_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_entry[ENTRY_W-3:0] != '0));

  p_hit_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_entry[ENTRY_W-1:ENTRY_W-2] != 2'b00));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !wr_ready);

  p_clear_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !scan_busy) |=> (!full || (list_sel != $past(list_sel))));

  p_full_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(wr_valid && wr_ready) || (list_sel != $past(list_sel))));
endmodule

bind tone_list_matcher tlm_checker #(.ENTRY_W(ENTRY_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .list_sel  (list_sel),
  .clear     (clear),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .scan_busy (scan_busy),
  .full      (full),
  .done      (done),
  .hit       (hit),
  .unlisted  (unlisted),
  .hit_entry (hit_entry)
);

// File: tb/tone_list_matcher_tb_top.sv
module tone_list_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        list_sel = 1'b0, clear = 1'b0, wr_valid = 1'b0, scan_start = 1'b0;
  logic [15:0] wr_entry = '0;
  logic [1:0]  grp_mode = 2'b00;
  logic [13:0] meas_code = '0, tol = '0;
  logic        wr_ready, done, hit, unlisted, full;
  logic [15:0] hit_entry;
  logic [4:0]  hit_loc;

  int tests = 0, fails = 0;
  logic [15:0] mdl [2][32];
  int          mcnt [2];

  always #10 clk = ~clk;

  tone_list_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .list_sel(list_sel), .clear(clear),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_entry(wr_entry),
    .grp_mode(grp_mode), .meas_code(meas_code), .tol(tol),
    .scan_start(scan_start), .done(done), .hit(hit), .unlisted(unlisted),
    .hit_entry(hit_entry), .hit_loc(hit_loc), .full(full)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_clear(input bit sel);
    list_sel = sel; clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < 32; i++) mdl[sel][i] = '0;
    mcnt[sel] = 0;
  endtask

  task automatic do_write(input bit sel, input logic [15:0] e);
    list_sel = sel; wr_entry = e; wr_valid = 1'b1;
    chk(wr_ready == 1'b1, "R2 ready", 32'(wr_ready), 1);
    @(negedge clk); wr_valid = 1'b0;
    if (mcnt[sel] < 32) begin
      mdl[sel][mcnt[sel]] = e; mcnt[sel]++;
    end else begin
      for (int i = 0; i < 31; i++) mdl[sel][i] = mdl[sel][i+1];
      mdl[sel][31] = e;
    end
  endtask

  task automatic predict(input bit sel, input logic [1:0] mode, input int meas,
                         input int tl, output logic [23:0] res, output int lat);
    bit found = 0, seen = 0;
    int loc = 0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] e = mdl[sel][i];
      int c = int'(e[13:0]);
      int d = (c > meas) ? c - meas : meas - c;
      bit nr = (c != 0) && (d <= tl);
      bit gk = (mode == 2'b10 && e[15]) || (mode == 2'b01 && e[14]);
      if (nr) seen = 1;
      if (nr && gk && !found) begin found = 1; loc = i; end
    end
    lat = found ? loc + 1 : 32;
    res = {found, (!found && !seen && (mode == 2'b10 || mode == 2'b01)),
           found ? loc[4:0] : 5'd0, found ? mdl[sel][loc] : 16'd0};
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
  endtask

  task automatic run_scan(input bit sel, input logic [1:0] mode, input int meas,
                          input int tl);
    logic [23:0] er, ar;
    int el, al;
    predict(sel, mode, meas, tl, er, el);
    list_sel = sel; grp_mode = mode; meas_code = 14'(meas); tol = 14'(tl);
    scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    wait_done(al);
    ar = {hit, unlisted, hit_loc, hit_entry};
    chk(al == el, "R11 latency", 32'(al), 32'(el));
    if (er[23])               chk(ar == er, "R7 R8 hit", 32'(ar), 32'(er));
    else if (mode == 2'b00 || mode == 2'b11)
                              chk(ar == er, "R1 R9 off", 32'(ar), 32'(er));
    else                      chk(ar == er, "R9 R10 miss", 32'(ar), 32'(er));
    @(negedge clk);
    chk(done == 1'b0, "R11 pulse", 32'(done), 0);
  endtask

  task automatic sweep(input bit sel);
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 3; t++)
        for (int v = 0; v <= 1000; v += 13)
          run_scan(sel, 2'(m), v, (t == 0) ? 0 : (t == 1) ? 4 : 25);
    for (int i = 0; i < 32; i++) begin
      run_scan(sel, 2'b10, int'(mdl[sel][i][13:0]), 0);
      run_scan(sel, 2'b01, int'(mdl[sel][i][13:0]), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] er, ar;
    int el, al;
    mcnt[0] = 0; mcnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, hit, unlisted, full, wr_ready} == 5'b00001, "R6 reset state",
        32'({done, hit, unlisted, full, wr_ready}), 1);

    do_clear(0); do_clear(1);
    chk(full == 1'b0, "R5 clear", 32'(full), 0);
    run_scan(0, 2'b10, 100, 5);  // empty list: unlisted

    // List 0: 20 entries, shared codes, one zero code, one group-00 entry
    for (int i = 0; i < 20; i++) begin
      logic [1:0]  g = (i % 3 == 0) ? 2'b10 : (i % 3 == 1) ? 2'b01 : 2'b11;
      logic [13:0] c = 14'(((i >> 1) + 1) * 40);
      if (i == 7) g = 2'b00;
      if (i == 5) c = '0;
      do_write(0, {g, c});
    end
    chk(full == 1'b0, "R4 partial", 32'(full), 0);

    // List 1: 40 writes, only the last 32 retained
    for (int k = 0; k < 40; k++)
      do_write(1, {(k % 2 == 1) ? 2'b11 : 2'b01, 14'(300 + k * 9)});
    chk(full == 1'b1, "R3 R4 overflow full", 32'(full), 1);
    list_sel = 1'b0; #1;
    chk(full == 1'b0, "R4 per list", 32'(full), 0);

    sweep(0);
    sweep(1);

    // R12: scan inputs captured at start; write and restart ignored mid-scan
    predict(0, 2'b10, 200, 0, er, el);
    list_sel = 1'b0; grp_mode = 2'b10; meas_code = 14'd200; tol = '0;
    scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(wr_ready == 1'b0, "R12 stall", 32'(wr_ready), 0);
    list_sel = 1'b1; meas_code = 14'd471; grp_mode = 2'b01; scan_start = 1'b1;
    wr_valid = 1'b1; wr_entry = 16'hBFFF;
    @(negedge clk); scan_start = 1'b0; wr_valid = 1'b0;
    wait_done(al); al = al + 1;
    ar = {hit, unlisted, hit_loc, hit_entry};
    chk(al == el, "R12 latency", 32'(al), 32'(el));
    chk(ar == er, "R12 captured", 32'(ar), 32'(er));
    @(negedge clk);
    run_scan(1, 2'b01, 471, 0);
    run_scan(0, 2'b10, 200, 0);

    // R5: clearing list 1 leaves list 0 alone
    do_clear(1);
    chk(full == 1'b0, "R5 clear full", 32'(full), 0);
    run_scan(1, 2'b01, 471, 30);
    for (int v = 0; v <= 440; v += 20) run_scan(0, 2'b10, v, 6);

    // R4 boundary at 31 and 32 entries
    for (int k = 0; k < 31; k++) do_write(1, {2'b10, 14'(700 + k * 5)});
    chk(full == 1'b0, "R4 at 31", 32'(full), 0);
    do_write(1, {2'b10, 14'(900)});
    chk(full == 1'b1, "R4 at 32", 32'(full), 1);

    // R6: reset keeps contents, clears full, restarts fill at location 0
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mcnt[0] = 0; mcnt[1] = 0;
    list_sel = 1'b1; #1;
    chk(full == 1'b0, "R6 full cleared", 32'(full), 0);
    for (int k = 0; k < 32; k += 3) run_scan(1, 2'b10, 700 + k * 5, 0);
    do_write(1, {2'b10, 14'(1234)});
    run_scan(1, 2'b10, 1234, 0);
    run_scan(1, 2'b10, 700, 0);
    run_scan(1, 2'b10, 705, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule